// File: doc/BRIEF.md
# Banked GPIO Port with Masked Data Writes

This block is a register-mapped general-purpose I/O port. It has `NUM_BANKS` banks of `BANK_W` lines each, 24 lines in three banks of eight by default. A small synchronous register bus reaches it. The bus carries an address, a two-lane write word with a lane strobe, a write enable and a combinational read-data byte. For each line the port holds an output value, a direction and a drive style. From these it produces a pad output-enable and a pad output-value for an external pad model. The pad input levels pass through a two-flop synchronizer and are read back through the data addresses.

Line `n` belongs to bank `n / BANK_W`, at bit `n % BANK_W`. Output values change only through a two-lane write to a bank's data address. Lane 0 carries the new values and lane 1 carries a per-bit mask, so single lines can be set or cleared without first reading the register back. Each output line drives in one of three styles: push-pull, open-drain (actively drives low, releases high) or open-source (actively drives high, releases low).

Address map (lane 0 writes the strobed address A, lane 1 writes A+1):
- data/mask pair of bank b: `2*b` (value) and `2*b+1` (mask).
- direction of bank b: `8+b`.
- open-drive enable of bank b: `16+2*b`, with its polarity at `17+2*b`.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every pad output-enable and pad output-value is 0. Every direction, open-enable and polarity register reads 0, so every line is an input in push-pull style with stored value 0.
- R2: A write with both lane strobes set (`bus_be = 2'b11`) to the data address `2*b` takes, for bank b, the lane-0 byte into exactly those lines whose bit is 1 in the lane-1 mask byte. Lines whose mask bit is 0 keep their previous value.
- R3: A write whose strobe is not `2'b11` leaves every stored output value unchanged. This covers value-only writes to a data address and mask-only writes to a mask address.
- R4: The direction register at `8+b` makes line bit i an output when bit i is 1 and an input when it is 0, and it reads back as written.
- R5: An output line whose open-enable bit is 0 (push-pull) has output-enable 1 and output-value equal to its stored value.
- R6: An output line with open-enable 1 and polarity 0 (open-drain) has output-enable equal to the inverse of its stored value and output-value 0.
- R7: An output line with open-enable 1 and polarity 1 (open-source) has output-enable equal to its stored value and output-value 1.
- R8: An input line has output-enable 0 and output-value 0, whatever its stored value and drive style.
- R9: Reading data address `2*b` returns the bank's pad input levels as they were two rising clock edges earlier. A pad change is not visible after one edge and is visible after the second.
- R10: In a two-lane write to a non-data address A, lane 0 writes register A and lane 1 writes register A+1 in the same cycle. For example, one write at `16+2*b` sets both the open-enable and the polarity of bank b.
- R11: Reads of a mask address, or of any address with no register, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 2*BANK_W | Write word; low byte is lane 0, high byte is lane 1 |
| bus_be | input | 2 | Lane strobes for lane 0 and lane 1 |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | BANK_W | Combinational read data for bus_addr |
| pad_i | input | NUM_BANKS*BANK_W | Pad input levels, one per line |
| pad_oe | output | NUM_BANKS*BANK_W | Pad output-enable, one per line |
| pad_o | output | NUM_BANKS*BANK_W | Pad output value, one per line |

## Verification
The hardest case to reach from the ports is an open-drive line that has released its pad. At that point the line's read-back level comes from outside while its stored value says otherwise, and a bug can hide there. The bench drives `pad_i` from a pad model that resolves each enabled driver over a separately chosen external level. It then sweeps every stored value under open-drain and open-source styles, and mixed styles within one bank. For the synchronizer lag, the external level is changed between edges and the read data is sampled after the first and after the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register address bases (bank index is added per kind)
   localparam int DATA_BASE = 0;    // value at 2*b, mask at 2*b+1
   localparam int DIR_BASE  = 8;    // direction at 8+b
   localparam int DRV_BASE  = 16;   // open-enable at 16+2*b, polarity at 17+2*b

   typedef enum logic [1:0] {
      DRV_PUSH_PULL  = 2'd0,
      DRV_OPEN_LOW   = 2'd1,
      DRV_OPEN_HIGH  = 2'd2
   } drive_e;

   function automatic drive_e drive_kind(input logic open_en, input logic high_side);
      if (!open_en)       return DRV_PUSH_PULL;
      else if (high_side) return DRV_OPEN_HIGH;
      else                return DRV_OPEN_LOW;
   endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic [W-1:0] data_val,
   input  logic [W-1:0] data_msk,
   input  logic         dir_we,
   input  logic [W-1:0] dir_d,
   input  logic         opn_we,
   input  logic [W-1:0] opn_d,
   input  logic         pol_we,
   input  logic [W-1:0] pol_d,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] opn_q,
   output logic [W-1:0] pol_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         opn_q <= '0;
         pol_q <= '0;
      end else begin
         if (data_we) out_q <= (out_q & ~data_msk) | (data_val & data_msk);
         if (dir_we)  dir_q <= dir_d;
         if (opn_we)  opn_q <= opn_d;
         if (pol_we)  pol_q <= pol_d;
      end
   end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_port_pkg::*;
(
   input  logic val,
   input  logic is_out,
   input  logic open_en,
   input  logic high_side,
   output logic oe,
   output logic o
);
   always_comb begin
      oe = 1'b0;
      o  = 1'b0;
      unique case (drive_kind(open_en, high_side))
         DRV_PUSH_PULL: begin oe = is_out;        o = is_out & val; end
         DRV_OPEN_LOW:  begin oe = is_out & ~val; o = 1'b0;         end
         DRV_OPEN_HIGH: begin oe = is_out & val;  o = is_out;       end
         default:       begin oe = 1'b0;          o = 1'b0;         end
      endcase
   end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [2*BANK_W-1:0]           bus_wdata,
   input  logic [1:0]                    bus_be,
   input  logic                          bus_we,
   output logic [BANK_W-1:0]             bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0]   pad_i,
   output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
   output logic [NUM_BANKS*BANK_W-1:0]   pad_o
);
   localparam int NL = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $fatal(1, "NUM_BANKS must lie in 1..4 to fit the address map");
   end
   if (BANK_W < 1) begin : g_bad_width
      $fatal(1, "BANK_W must be at least 1");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $fatal(1, "ADDR_W must be at least 5");
   end

   logic [BANK_W-1:0] lane0, lane1;
   assign lane0 = bus_wdata[BANK_W-1:0];
   assign lane1 = bus_wdata[2*BANK_W-1:BANK_W];

   logic [NL-1:0] out_all, dir_all, opn_all, pol_all, sync_all;

   gpio_sync2 #(.W(NL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_i), .q(sync_all)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DATA_BASE + 2*b);
      localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + b);
      localparam logic [ADDR_W-1:0] A_OPN = ADDR_W'(DRV_BASE + 2*b);
      localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(DRV_BASE + 2*b + 1);

      logic dir_l0, dir_l1, opn_l0, opn_l1, pol_l0, pol_l1, dat_we;

      assign dat_we = bus_we && (bus_be == 2'b11) && (bus_addr == A_DAT);
      assign dir_l0 = bus_we && bus_be[0] && (bus_addr == A_DIR);
      assign dir_l1 = bus_we && bus_be[1] && (bus_addr == ADDR_W'(DIR_BASE + b - 1));
      assign opn_l0 = bus_we && bus_be[0] && (bus_addr == A_OPN);
      assign opn_l1 = bus_we && bus_be[1] && (bus_addr == ADDR_W'(DRV_BASE + 2*b - 1));
      assign pol_l0 = bus_we && bus_be[0] && (bus_addr == A_POL);
      assign pol_l1 = bus_we && bus_be[1] && (bus_addr == A_OPN);

      gpio_bank_regs #(.W(BANK_W)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .data_we  (dat_we),
         .data_val (lane0),
         .data_msk (lane1),
         .dir_we   (dir_l0 | dir_l1),
         .dir_d    (dir_l0 ? lane0 : lane1),
         .opn_we   (opn_l0 | opn_l1),
         .opn_d    (opn_l0 ? lane0 : lane1),
         .pol_we   (pol_l0 | pol_l1),
         .pol_d    (pol_l0 ? lane0 : lane1),
         .out_q    (out_all[b*BANK_W +: BANK_W]),
         .dir_q    (dir_all[b*BANK_W +: BANK_W]),
         .opn_q    (opn_all[b*BANK_W +: BANK_W]),
         .pol_q    (pol_all[b*BANK_W +: BANK_W])
      );
   end

   for (genvar n = 0; n < NL; n++) begin : g_line
      gpio_pad_drive u_drv (
         .val       (out_all[n]),
         .is_out    (dir_all[n]),
         .open_en   (opn_all[n]),
         .high_side (pol_all[n]),
         .oe        (pad_oe[n]),
         .o         (pad_o[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(DATA_BASE + 2*b))    bus_rdata = sync_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(DIR_BASE + b))       bus_rdata = dir_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(DRV_BASE + 2*b))     bus_rdata = opn_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(DRV_BASE + 2*b + 1)) bus_rdata = pol_all[b*BANK_W +: BANK_W];
      end
   end
endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [2*BANK_W-1:0]         bus_wdata,
   input logic [1:0]                  bus_be,
   input logic                        bus_we,
   input logic [NUM_BANKS*BANK_W-1:0] pad_i,
   input logic [NUM_BANKS*BANK_W-1:0] pad_oe,
   input logic [NUM_BANKS*BANK_W-1:0] pad_o,
   input logic [NUM_BANKS*BANK_W-1:0] out_all,
   input logic [NUM_BANKS*BANK_W-1:0] dir_all,
   input logic [NUM_BANKS*BANK_W-1:0] opn_all,
   input logic [NUM_BANKS*BANK_W-1:0] pol_all,
   input logic [NUM_BANKS*BANK_W-1:0] sync_all
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pad_oe == '0 && pad_o == '0 && out_all == '0));

   p_partial_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_be != 2'b11) |=> $stable(out_all));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
      localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DATA_BASE + 2*b);
      p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_be == 2'b11 && bus_addr == A_DAT) |=>
         ((out_all[b*BANK_W +: BANK_W] & ~$past(bus_wdata[2*BANK_W-1:BANK_W])) ==
          ($past(out_all[b*BANK_W +: BANK_W]) & ~$past(bus_wdata[2*BANK_W-1:BANK_W]))));
   end

   p_open_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_o & dir_all & opn_all & ~pol_all) == '0));

   p_open_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~pad_o & dir_all & opn_all & pol_all) == '0));

   p_input_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_all) == '0));

   p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (sync_all == $past(pad_i, 2)));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
   .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_be(bus_be), .bus_we(bus_we), .pad_i(pad_i), .pad_oe(pad_oe),
   .pad_o(pad_o), .out_all(out_all), .dir_all(dir_all), .opn_all(opn_all),
   .pol_all(pol_all), .sync_all(sync_all)
);

// File: tb/gpio_bank_port_bench.sv
module gpio_bank_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 3;
   localparam int W  = 8;
   localparam int NL = NB * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [1:0]    bus_be = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_rdata;
   logic [NL-1:0] pad_i, pad_oe, pad_o;
   logic [NL-1:0] ext_lvl = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // pad model: an enabled driver wins, otherwise the external level
   assign pad_i = (pad_oe & pad_o) | (~pad_oe & ext_lvl);

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_port #(.NUM_BANKS(NB), .BANK_W(W), .ADDR_W(6)) u_gpio_bank_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata),
      .pad_i(pad_i), .pad_oe(pad_oe), .pad_o(pad_o)
   );

   // reference state built from the requirements
   logic [7:0] m_out [NB];
   logic [7:0] m_dir [NB];
   logic [7:0] m_opn [NB];
   logic [7:0] m_pol [NB];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2*NL-1:0] exp_pads();
      logic [NL-1:0] oe, o;
      for (int n = 0; n < NL; n++) begin
         logic v, d, e, p;
         v = m_out[n/W][n%W]; d = m_dir[n/W][n%W];
         e = m_opn[n/W][n%W]; p = m_pol[n/W][n%W];
         if (!d)      begin oe[n] = 0;  o[n] = 0; end   // R8
         else if (!e) begin oe[n] = 1;  o[n] = v; end   // R5
         else if (!p) begin oe[n] = !v; o[n] = 0; end   // R6
         else         begin oe[n] = v;  o[n] = 1; end   // R7
      end
      return {oe, o};
   endfunction

   task automatic check_pads(input string tag);
      logic [2*NL-1:0] e;
      e = exp_pads();
      check(pad_oe == e[2*NL-1:NL], {tag, " oe"}, 32'(pad_oe), 32'(e[2*NL-1:NL]));
      check(pad_o == e[NL-1:0], {tag, " o"}, 32'(pad_o), 32'(e[NL-1:0]));
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_be = 2'b00;
      #1;
   endtask

   task automatic read_check(input logic [5:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, tag, 32'(bus_rdata), 32'(exp));
   endtask

   task automatic masked_write(input int b, input logic [7:0] v, input logic [7:0] m);
      bus_write(6'(2*b), {m, v}, 2'b11);
      m_out[b] = (m_out[b] & ~m) | (v & m);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin
         m_out[b] = '0; m_dir[b] = '0; m_opn[b] = '0; m_pol[b] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1: reset state
      check(pad_oe == '0, "R1 oe", 32'(pad_oe), 0);
      check(pad_o == '0, "R1 o", 32'(pad_o), 0);
      for (int b = 0; b < NB; b++) begin
         read_check(6'(8+b), 8'h00, "R1 dir");
         read_check(6'(16+2*b), 8'h00, "R1 opn");
         read_check(6'(17+2*b), 8'h00, "R1 pol");
      end

      // R4: direction write and read-back, then make all outputs
      for (int b = 0; b < NB; b++) begin
         logic [7:0] pat;
         pat = 8'(8'hA5 ^ (b * 8'h3C));
         bus_write(6'(8+b), {8'h00, pat}, 2'b01);
         m_dir[b] = pat;
         read_check(6'(8+b), pat, "R4 dir readback");
         check_pads("R4/R8 partial dir");
         bus_write(6'(8+b), 16'h00FF, 2'b01);
         m_dir[b] = 8'hFF;
      end

      // R2/R5: masked writes sweep in push-pull
      for (int b = 0; b < NB; b++) begin
         for (int k = 0; k < 64; k++) begin
            masked_write(b, 8'(k*53 + b*17), 8'(((k*29) + 7) ^ (k << 3)));
            check_pads("R2/R5 masked push-pull");
         end
      end

      // R3: partial-strobe writes change nothing
      for (int b = 0; b < NB; b++) begin
         bus_write(6'(2*b), {8'hFF, ~m_out[b]}, 2'b01);
         check_pads("R3 value-only");
         bus_write(6'(2*b), {8'hFF, ~m_out[b]}, 2'b10);
         check_pads("R3 mask lane only");
         bus_write(6'(2*b+1), {~m_out[b], 8'hFF}, 2'b01);
         check_pads("R3 mask address");
      end

      // R10/R6: one burst sets open-enable and polarity of bank 1
      bus_write(6'd18, 16'h00FF, 2'b11);
      m_opn[1] = 8'hFF; m_pol[1] = 8'h00;
      read_check(6'd18, 8'hFF, "R10 lane0 opn");
      read_check(6'd19, 8'h00, "R10 lane1 pol");
      for (int v = 0; v < 256; v++) begin
         masked_write(1, 8'(v), 8'hFF);
         check_pads("R6 open-drain");
      end

      // R10/R7: open-source
      bus_write(6'd18, 16'hFFFF, 2'b11);
      m_pol[1] = 8'hFF;
      read_check(6'd19, 8'hFF, "R10 pol set");
      for (int v = 0; v < 256; v++) begin
         masked_write(1, 8'(v), 8'hFF);
         check_pads("R7 open-source");
      end

      // R10: burst to direction base writes two banks; mixed styles in bank 0
      bus_write(6'd8, 16'hFFFF, 2'b11);
      read_check(6'd9, 8'hFF, "R10 dir lane1");
      bus_write(6'd16, 16'h550F, 2'b11);
      m_opn[0] = 8'h0F; m_pol[0] = 8'h55;
      for (int v = 0; v < 256; v += 7) begin
         masked_write(0, 8'(v), 8'hFF);
         check_pads("R5/R6/R7 mixed");
      end

      // R8/R9: bank 2 inputs, read-back lag
      bus_write(6'd10, 16'h0000, 2'b01);
      m_dir[2] = 8'h00;
      check_pads("R8 inputs");
      for (int k = 0; k < 24; k++) begin
         logic [NL-1:0] prev_ext, nx;
         logic [7:0] old_lvl, new_lvl;
         prev_ext = ext_lvl;
         nx = NL'(k * 24'h9E3779) ^ NL'(k << 5);
         old_lvl = prev_ext[23:16];
         new_lvl = nx[23:16];
         @(negedge clk);
         ext_lvl = nx;
         bus_addr = 6'd4;
         @(negedge clk); #1;
         check(bus_rdata == old_lvl, "R9 after one edge", 32'(bus_rdata), 32'(old_lvl));
         @(negedge clk); #1;
         check(bus_rdata == new_lvl, "R9 after two edges", 32'(bus_rdata), 32'(new_lvl));
         check_pads("R8 inputs under level change");
      end

      // R9: open-drain line released reads the external level
      bus_write(6'd18, 16'h00FF, 2'b11);
      m_pol[1] = 8'h00;
      masked_write(1, 8'hF0, 8'hFF);
      ext_lvl[15:8] = 8'h3C;
      repeat (2) @(negedge clk);
      read_check(6'd2, 8'h30, "R9 open-drain read-back");

      // R11: mask and empty addresses read zero
      read_check(6'd1, 8'h00, "R11 mask addr");
      read_check(6'd3, 8'h00, "R11 mask addr");
      read_check(6'd6, 8'h00, "R11 empty bank data");
      read_check(6'd12, 8'h00, "R11 empty");
      read_check(6'd31, 8'h00, "R11 empty");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule